// File: doc/BRIEF.md
# Paged Edge-Capture Digital I/O Controller

This block is a byte-wide register peripheral for 48 general-purpose lines, grouped as six 8-bit ports. A host reaches it through a 4-bit address, an 8-bit write bus with a write strobe, and a combinational read bus. Each port has an output latch that drives its eight lines. A read of a port returns the synchronized level of its eight input lines.

The lowest three ports can also raise interrupts. Each of their lines passes through a two-flop synchronizer. An edge is then latched when the line is enabled and moves in the direction that its polarity bit selects. Three address slots form a window, and a 2-bit page field switches it between three per-port banks: polarity, enable, and the latched edge flags. The page field lives in a write-only control register. The low six bits of that register are write locks for the six ports. A read-only summary register shows which interrupt-capable ports hold flags, and a single interrupt line gathers every latched, enabled flag.

The host's interrupt handler reads the summary, switches to the flag page, reads each pending port, and writes zero to acknowledge. Writing a nonzero mask keeps only the flags whose mask bit is one.

Top module: `pdio_ctrl`

## Requirements
- R1: After reset, pin_out is zero, irq_o and pend_o are zero, the page is 0, and no port is locked.
- R2: A write to address i (0 to 5) loads port i's output latch, which drives pin_out[8i+7:8i]. A read of address i returns the synchronized level of pin_in[8i+7:8i]. Both work on every page.
- R3: Address 7 is write-only and reads as zero. In the written byte, bits 7:6 select the page and bit i (0 to 5) locks port i. A write to a locked port leaves its output latch unchanged.
- R4: On page 1, addresses 8, 9 and 10 write the per-bit edge polarity of ports 0, 1 and 2. A polarity of 1 latches rising edges and 0 latches falling edges. Slots on pages 1 and 2 read as zero.
- R5: On page 2, addresses 8, 9 and 10 write the per-bit interrupt enables of ports 0, 1 and 2. A line whose enable bit is 0 never latches an edge.
- R6: On page 3, a read of address 8+j returns port j's latched edge flags. A write there keeps only the flags whose data bit is 1, so writing zero clears them all.
- R7: Address 6 is read-only on every page. Bit j (j = 0 to 2) is 1 exactly when port j holds a latched flag, and bits 7:3 read as zero. pend_o carries the same three bits.
- R8: irq_o is the OR of all latched flags ANDed with their enables. It stays high until the flags are cleared.
- R9: Lines of ports 3 to 5 never latch edges, never affect irq_o, and address 11 has no effect on any page.
- R10: On page 0, addresses 8 to 10 read as zero, and writes to them change no polarity, enable or flag.
- R11: Suppose an input changes between two clock edges. The resulting flag (and irq_o) is absent after the second following rising edge and present after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 48 | Input levels of the six ports |
| pin_out | output | 48 | Output latches of the six ports |
| pend_o | output | 3 | Per-port pending summary for ports 0 to 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench looks for the following faults:
- A lock that blocks the wrong port, or that blocks no port at all, shows up as a changed output byte.
- A window that decodes while on page 0, or that ignores the page, leaks writes into the enable bank and raises an interrupt that should not occur.
- A polarity sense that is inverted latches the falling edge of a rising-only line.
- A clear that ignores the mask drops flags on a nonzero write.
- A missing synchronizer stage moves the flag one cycle earlier. The bench samples irq_o at the exact cycle to catch this.
- Edge logic wired up for the upper three ports shows up as pending bits when those lines toggle.

// File: rtl/pdio_pkg.sv
package pdio_pkg;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;

  localparam int ADDR_PEND = 6;
  localparam int ADDR_CTRL = 7;
  localparam int ADDR_WIN0 = 8;

endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/pdio_edge_port.sv
module pdio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         pol_we,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic         hit,
  output logic         any
);

  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] pol_q, pol_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] flg_q, flg_d;
  logic [W-1:0] rise, fall, seen;

  always_comb begin
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
    seen   = (pol_q & rise) | (~pol_q & fall);
    prev_d = lvl;
    pol_d  = pol_q;
    en_d   = en_q;
    flg_d  = flg_q;
    if (pol_we) pol_d = wdata;
    if (en_we)  en_d  = wdata;
    if (clr_we) flg_d = flg_q & wdata;
    flg_d = flg_d | (seen & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      flg_q  <= '0;
    end else begin
      prev_q <= prev_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
      flg_q  <= flg_d;
    end
  end

  assign flags = flg_q;
  assign hit   = |(flg_q & en_q);
  assign any   = |flg_q;

  // R6: without a clear write, latched flags never drop
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

  // R5: a newly set flag needs its enable bit in the cycle before
  p_flag_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg_q & ~$past(flg_q) & ~$past(en_q)) == '0));

endmodule

// File: rtl/pdio_ctrl.sv
module pdio_ctrl
  import pdio_pkg::*;
#(
  parameter int PORTS     = 6,
  parameter int IRQ_PORTS = 3,
  parameter int W         = 8,
  parameter int AW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  input  logic [PORTS*W-1:0]   pin_in,
  output logic [PORTS*W-1:0]   pin_out,
  output logic [IRQ_PORTS-1:0] pend_o,
  output logic                 irq_o
);

  localparam int LINES = PORTS * W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end
  assign rst_i = rst_q;

  // synchronized input levels
  logic [LINES-1:0] lvl;
  pdio_sync #(.W(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_i),
    .d    (pin_in),
    .q    (lvl)
  );

  // control register: page and locks
  page_e            page_q, page_d;
  logic [PORTS-1:0] lock_q, lock_d;
  logic             ctrl_we;

  assign ctrl_we = bus_wr && (bus_addr == AW'(ADDR_CTRL));

  always_comb begin
    page_d = page_q;
    lock_d = lock_q;
    if (ctrl_we) begin
      page_d = page_e'(bus_wdata[W-1:W-2]);
      lock_d = bus_wdata[PORTS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else begin
      page_q <= page_d;
      lock_q <= lock_d;
    end
  end

  // port output latches
  logic [PORTS-1:0] port_sel;
  logic [LINES-1:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    for (int i = 0; i < PORTS; i++) begin
      port_sel[i] = bus_wr && (bus_addr == AW'(i));
      if (port_sel[i] && !lock_q[i]) out_d[i*W +: W] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pin_out = out_q;

  // edge-capable ports
  logic [W-1:0]         flags_a [IRQ_PORTS];
  logic [IRQ_PORTS-1:0] hit_a;
  logic [IRQ_PORTS-1:0] any_a;

  for (genvar j = 0; j < IRQ_PORTS; j++) begin : g_edge
    logic win_we;
    assign win_we = bus_wr && (bus_addr == AW'(ADDR_WIN0 + j));

    pdio_edge_port #(.W(W)) u_port (
      .clk   (clk),
      .rst_n (rst_i),
      .lvl   (lvl[j*W +: W]),
      .pol_we(win_we && (page_q == PG_POL)),
      .en_we (win_we && (page_q == PG_EN)),
      .clr_we(win_we && (page_q == PG_ID)),
      .wdata (bus_wdata),
      .flags (flags_a[j]),
      .hit   (hit_a[j]),
      .any   (any_a[j])
    );
  end

  assign pend_o = any_a;
  assign irq_o  = |hit_a;

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < PORTS; i++) begin
      if (bus_addr == AW'(i)) bus_rdata = lvl[i*W +: W];
    end
    if (bus_addr == AW'(ADDR_PEND)) bus_rdata = W'(any_a);
    for (int j = 0; j < IRQ_PORTS; j++) begin
      if ((bus_addr == AW'(ADDR_WIN0 + j)) && (page_q == PG_ID))
        bus_rdata = flags_a[j];
    end
  end

  // R3: a write aimed at a locked port leaves every output latch as it was
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (|(port_sel & lock_q)) |=> $stable(out_q));

  // R8: the interrupt line implies at least one pending port
  p_irq_pend_r8: assert property (@(posedge clk) disable iff (!rst_i)
    irq_o |-> (pend_o != '0));

endmodule

// File: tb/pdio_ctrl_test.sv
module pdio_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [47:0] pin_in;
  logic [47:0] pin_out;
  logic [2:0]  pend;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdio_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (addr),
    .bus_wr   (wr),
    .bus_wdata(wdata),
    .bus_rdata(rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pend_o   (pend),
    .irq_o    (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pend", pend, 0);
    rd_reg(4'd8, v);
    chk("R1/R10 page0 window read", v, 0);
  endtask

  task automatic t_ports;
    logic [7:0] v;
    wr_reg(4'd0, 8'hA5);
    chk("R2 port0 out", pin_out[7:0], 8'hA5);
    wr_reg(4'd5, 8'h3C);
    chk("R2 port5 out", pin_out[47:40], 8'h3C);
    @(negedge clk); pin_in[23:16] = 8'h5A;
    idle(3);
    rd_reg(4'd2, v);
    chk("R2 port2 read", v, 8'h5A);
    wr_reg(4'd7, 8'hC0);
    wr_reg(4'd1, 8'h77);
    chk("R2 port1 write on page3", pin_out[15:8], 8'h77);
    wr_reg(4'd7, 8'h00);
  endtask

  task automatic t_lock;
    logic [7:0] v;
    wr_reg(4'd7, 8'h02);
    wr_reg(4'd1, 8'hFF);
    chk("R3 locked port1 holds", pin_out[15:8], 8'h77);
    wr_reg(4'd0, 8'h11);
    chk("R3 unlocked port0 writes", pin_out[7:0], 8'h11);
    rd_reg(4'd7, v);
    chk("R3 ctrl reads zero", v, 0);
    wr_reg(4'd7, 8'h00);
    wr_reg(4'd1, 8'hFF);
    chk("R3 unlock restores write", pin_out[15:8], 8'hFF);
  endtask

  task automatic t_wo_reads;
    logic [7:0] v;
    wr_reg(4'd7, 8'h40);
    rd_reg(4'd8, v);
    chk("R4 polarity slot reads zero", v, 0);
    wr_reg(4'd7, 8'h80);
    rd_reg(4'd9, v);
    chk("R4 enable slot reads zero", v, 0);
  endtask

  task automatic t_page0;
    logic [7:0] v;
    wr_reg(4'd7, 8'h40);
    wr_reg(4'd9, 8'hFF);
    wr_reg(4'd7, 8'h00);
    wr_reg(4'd9, 8'hFF);
    rd_reg(4'd9, v);
    chk("R10 page0 read zero", v, 0);
    @(negedge clk); pin_in[15:8] = 8'hFF;
    idle(4);
    chk("R10/R5 page0 write left enable off", irq, 0);
    rd_reg(4'd6, v);
    chk("R10/R5 no pending", v, 0);
    @(negedge clk); pin_in[15:8] = 8'h00;
    idle(4);
  endtask

  task automatic t_rise;
    logic [7:0] v;
    wr_reg(4'd7, 8'h40);
    wr_reg(4'd8, 8'h01);
    wr_reg(4'd7, 8'h80);
    wr_reg(4'd8, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 no flag after two edges", irq, 0);
    @(posedge clk); #1;
    chk("R11 flag after third edge", irq, 1);
    @(negedge clk);
    rd_reg(4'd6, v);
    chk("R7 pending port0", v, 8'h01);
    chk("R7 pend_o", pend, 3'b001);
    wr_reg(4'd7, 8'hC0);
    rd_reg(4'd8, v);
    chk("R6 id port0", v, 8'h01);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    chk("R8 irq held", irq, 1);
    rd_reg(4'd8, v);
    chk("R4 falling not latched on rising bit", v, 8'h01);
    wr_reg(4'd8, 8'h00);
    chk("R8 irq drops after clear", irq, 0);
    rd_reg(4'd6, v);
    chk("R6 pending cleared", v, 0);
  endtask

  task automatic t_fall;
    logic [7:0] v;
    @(negedge clk); pin_in[23] = 1'b1;
    idle(4);
    wr_reg(4'd7, 8'h40);
    wr_reg(4'd10, 8'h00);
    wr_reg(4'd7, 8'h80);
    wr_reg(4'd10, 8'h80);
    @(negedge clk); pin_in[23] = 1'b0;
    idle(4);
    chk("R4 falling edge irq", irq, 1);
    rd_reg(4'd6, v);
    chk("R7 pending port2", v, 8'h04);
    wr_reg(4'd7, 8'hC0);
    rd_reg(4'd10, v);
    chk("R6 id port2", v, 8'h80);
    wr_reg(4'd10, 8'hFF);
    rd_reg(4'd10, v);
    chk("R6 mask write keeps flag", v, 8'h80);
    wr_reg(4'd10, 8'h00);
    rd_reg(4'd10, v);
    chk("R6 zero write clears", v, 0);
    chk("R8 irq low", irq, 0);
  endtask

  task automatic t_upper;
    logic [7:0] v;
    wr_reg(4'd7, 8'h80);
    wr_reg(4'd11, 8'hFF);
    @(negedge clk); pin_in[47:24] = 24'hFFFFFF;
    idle(4);
    chk("R9 upper ports no irq", irq, 0);
    rd_reg(4'd6, v);
    chk("R9 upper ports no pending", v, 0);
    rd_reg(4'd3, v);
    chk("R2/R9 port3 read on page2", v, 8'hFF);
    @(negedge clk); pin_in[47:24] = 24'h0;
    idle(4);
    chk("R9 falling upper no irq", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_ports;
    t_lock;
    t_wo_reads;
    t_page0;
    t_rise;
    t_fall;
    t_upper;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule